// File: doc/BRIEF.md
# Stepped I2C Bus Master

The block is a single-master I2C controller that a host processor walks through a transfer one bus action at a time. Through a small register window the host asks for a START, a repeated START, a STOP, the transmission of one byte or the reception of one byte. When the action has finished the block parks the bus and raises a completion flag. The host then decides the next step.

SCL and SDA are open-drain. The block only pulls a line low or lets it go, and it reads SDA back through an input. A reload counter sets the SCL half-period. That counter runs only while an action is in progress. After every byte, SCL is left low until the host issues the next request.

The host is responsible for the content of the first byte after a START. That byte is the 7-bit slave address followed by the direction bit: 0 asks the slave to accept data and 1 asks it to send data. Received acknowledge values are latched for the host to read. For received bytes, the acknowledge the block returns comes from a control bit.

Top module: `i2c_step_master`

## Requirements
- R1: Writing 1 to control bit 0 (START) or bit 1 (repeated START) at address 1 runs the same sequence. SDA is released for one half-period while SCL keeps its parked level. SCL is then released for one half-period. SDA falls while SCL is high and is held for one half-period. Finally SCL is pulled low. The request bit reads back 1 until the sequence ends and then clears itself.
- R2: Writing 1 to control bit 2 (STOP) runs the following sequence. SDA is pulled low while SCL is low. SCL is released. SDA rises while SCL is high. After one more half-period both lines are released, and bit 2 clears itself.
- R3: One SCL half-period lasts H = max(r,1)+1 clocks, where r is the low 7 bits of address 2. The completion flag goes high on the rising edge that comes 3·H+1 edges after the edge that accepts a START or STOP request, and 18·H+1 edges after the edge that accepts a byte request.
- R4: Writing address 0 sends that byte over eight SCL pulses, most-significant bit first. During a byte, SDA changes only while SCL is low.
- R5: On the ninth clock of a transmitted byte, SDA is released and sampled on the SCL high phase. The sampled level is stored in control bit 6, where 0 means acknowledged and 1 means not acknowledged. Bit 6 changes only at the end of a transmitted byte.
- R6: Writing 1 to control bit 3 receives one byte, most-significant bit first, and makes it readable at address 0. On the ninth clock the block drives the level of control bit 5 (0 pulls SDA low as an acknowledge; 1 leaves SDA released).
- R7: At the end of each byte SCL is held low. No further SCL edges occur until the next request.
- R8: The completion flag is bit 0 of address 3 and also appears on `irq`. Writing 0 to bit 0 clears the flag and writing 1 has no effect. If a completion and a clearing write fall on the same edge, the flag ends up set.
- R9: While an action is pending or in progress, writes to addresses 0, 1 and 2 are ignored.
- R10: If one control write sets several request bits, only the highest-priority one is kept. The priority order is START (bit 0), then repeated START (bit 1), then STOP (bit 2), then receive (bit 3).
- R11: After reset both lines are released, the flag is 0, and the control, buffer and reload registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 buffer, 1 control, 2 reload, 3 flag) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Completion flag |
| sda_i | input | 1 | Level on the SDA wire |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The completion of an action sets the flag, and a host write can clear it. These two events can land on the same clock edge. The bench computes that edge from the half-period formula. It schedules a clearing write so that its accepting edge is exactly the edge on which a START completes, then checks that the flag still reads 1. It also checks that a later, non-colliding clear does take effect.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    ENG_IDLE,
    ENG_ST_A,
    ENG_ST_B,
    ENG_ST_C,
    ENG_SP_A,
    ENG_SP_B,
    ENG_SP_C,
    ENG_BLO,
    ENG_BHI
  } eng_state_t;

  typedef enum logic [1:0] {
    OP_START,
    OP_STOP,
    OP_TX,
    OP_RX
  } op_t;

  localparam logic [1:0] A_BUF  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_BAUD = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  localparam int CB_START  = 0;
  localparam int CB_RSTART = 1;
  localparam int CB_STOP   = 2;
  localparam int CB_RECV   = 3;
  localparam int CB_NACK   = 5;
  localparam int CB_ACKST  = 6;

endpackage

// File: rtl/i2cm_baud.sv
module i2cm_baud #(
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [RW-1:0] reload,
  output logic          tick
);

  logic [RW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] reload_eff;

  // a reload of zero would leave no cycle between SCL edges for SDA to move
  assign reload_eff = (reload == '0) ? RW'(1) : reload;
  assign tick       = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || cnt_q == '0) cnt_d = reload_eff;
    else                    cnt_d = cnt_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick) |=> !tick); // R3

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  op_t           op,
  input  logic [DW-1:0] tx_byte,
  input  logic          nack_send,
  input  logic          tick,
  input  logic          sda_i,
  output logic          busy,
  output logic          done,
  output op_t           done_op,
  output logic          ack_smp,
  output logic [DW-1:0] rx_byte,
  output logic          scl_low,
  output logic          sda_low
);

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  eng_state_t    state_q, state_d;
  op_t           op_q, op_d;
  logic          scl_q, scl_d;
  logic          sda_q, sda_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] bit_q, bit_d;
  logic          drive_bit;
  logic          in_byte;

  assign busy    = (state_q != ENG_IDLE);
  assign in_byte = (state_q == ENG_BLO) || (state_q == ENG_BHI);
  assign done_op = op_q;
  assign ack_smp = sda_i;
  assign rx_byte = sh_q;
  assign scl_low = scl_q;
  assign sda_low = sda_q;

  always_comb begin
    if (bit_q == LAST) drive_bit = (op_q == OP_TX) ? 1'b0 : !nack_send;
    else               drive_bit = (op_q == OP_TX) ? !sh_q[DW-1] : 1'b0;
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    sh_d    = sh_q;
    bit_d   = bit_q;
    done    = 1'b0;
    case (state_q)
      ENG_IDLE: if (go) begin
        op_d = op;
        case (op)
          OP_START: begin state_d = ENG_ST_A; sda_d = 1'b0; end
          OP_STOP:  begin state_d = ENG_SP_A; sda_d = 1'b1; end
          default: begin
            state_d = ENG_BLO;
            scl_d   = 1'b1;
            bit_d   = '0;
            sh_d    = (op == OP_TX) ? tx_byte : '1;
          end
        endcase
      end
      ENG_ST_A: if (tick) begin scl_d = 1'b0; state_d = ENG_ST_B; end
      ENG_ST_B: if (tick) begin sda_d = 1'b1; state_d = ENG_ST_C; end
      ENG_ST_C: if (tick) begin scl_d = 1'b1; state_d = ENG_IDLE; done = 1'b1; end
      ENG_SP_A: if (tick) begin scl_d = 1'b0; state_d = ENG_SP_B; end
      ENG_SP_B: if (tick) begin sda_d = 1'b0; state_d = ENG_SP_C; end
      ENG_SP_C: if (tick) begin state_d = ENG_IDLE; done = 1'b1; end
      ENG_BLO: begin
        if (scl_q) sda_d = drive_bit;
        if (tick) begin scl_d = 1'b0; state_d = ENG_BHI; end
      end
      ENG_BHI: if (tick) begin
        scl_d = 1'b1;
        if (bit_q == LAST) begin
          state_d = ENG_IDLE;
          done    = 1'b1;
        end else begin
          sh_d    = {sh_q[DW-2:0], sda_i};
          bit_d   = bit_q + CW'(1);
          state_d = ENG_BLO;
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      op_q    <= OP_START;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      sh_q    <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      sh_q    <= sh_d;
      bit_q   <= bit_d;
    end
  end

  AST_SDA_MOVES_UNDER_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && (sda_q != $past(sda_q))) |-> (scl_q && $past(scl_q))); // R4
  AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_ST_C && $past(state_q) == ENG_ST_B) |-> (!scl_q && sda_q)); // R1
  AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_SP_C && $past(state_q) == ENG_SP_B) |-> (!scl_q && !sda_q)); // R2
  AST_PARK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_TX || op_q == OP_RX)) |=> (scl_q && !busy)); // R7

endmodule

// File: rtl/i2cm_hostregs.sv
module i2cm_hostregs
  import i2cm_pkg::*;
#(
  parameter int DW = 8,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          eng_busy,
  input  logic          done,
  input  op_t           done_op,
  input  logic          ack_smp,
  input  logic [DW-1:0] rx_byte,
  output logic          go,
  output op_t           op,
  output logic [DW-1:0] tx_byte,
  output logic          nack,
  output logic [RW-1:0] reload,
  output logic          flag
);

  logic [3:0]    req_q, req_d, pick;
  logic          txp_q, txp_d;
  logic [DW-1:0] txb_q, txb_d;
  logic [DW-1:0] rxb_q, rxb_d;
  logic          nack_q, nack_d;
  logic          ackst_q, ackst_d;
  logic [RW-1:0] rl_q, rl_d;
  logic          flag_q, flag_d;
  logic          pend, locked;

  assign pend    = (|req_q) || txp_q;
  assign locked  = eng_busy || pend;
  assign go      = pend && !eng_busy;
  assign tx_byte = txb_q;
  assign nack    = nack_q;
  assign reload  = rl_q;
  assign flag    = flag_q;

  always_comb begin
    if      (req_q[CB_START] || req_q[CB_RSTART]) op = OP_START;
    else if (req_q[CB_STOP])                      op = OP_STOP;
    else if (req_q[CB_RECV])                      op = OP_RX;
    else                                          op = OP_TX;
  end

  always_comb begin
    pick = 4'b0000;
    if      (wdata[CB_START])  pick[CB_START]  = 1'b1;
    else if (wdata[CB_RSTART]) pick[CB_RSTART] = 1'b1;
    else if (wdata[CB_STOP])   pick[CB_STOP]   = 1'b1;
    else if (wdata[CB_RECV])   pick[CB_RECV]   = 1'b1;
  end

  always_comb begin
    req_d   = req_q;
    txp_d   = txp_q;
    txb_d   = txb_q;
    rxb_d   = rxb_q;
    nack_d  = nack_q;
    ackst_d = ackst_q;
    rl_d    = rl_q;
    flag_d  = flag_q;
    if (we && !locked) begin
      case (addr)
        A_BUF:  begin txb_d = wdata; txp_d = 1'b1; end
        A_CTRL: begin req_d = pick; nack_d = wdata[CB_NACK]; end
        A_BAUD: rl_d = wdata[RW-1:0];
        default: ;
      endcase
    end
    if (we && addr == A_FLAG && !wdata[0]) flag_d = 1'b0;
    if (done) begin
      req_d  = '0;
      txp_d  = 1'b0;
      flag_d = 1'b1;
      if (done_op == OP_TX) ackst_d = ack_smp;
      if (done_op == OP_RX) rxb_d   = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      txp_q   <= 1'b0;
      txb_q   <= '0;
      rxb_q   <= '0;
      nack_q  <= 1'b0;
      ackst_q <= 1'b0;
      rl_q    <= '0;
      flag_q  <= 1'b0;
    end else begin
      req_q   <= req_d;
      txp_q   <= txp_d;
      txb_q   <= txb_d;
      rxb_q   <= rxb_d;
      nack_q  <= nack_d;
      ackst_q <= ackst_d;
      rl_q    <= rl_d;
      flag_q  <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_BUF:  rdata = rxb_q;
      A_CTRL: begin
        rdata[3:0]      = req_q;
        rdata[CB_NACK]  = nack_q;
        rdata[CB_ACKST] = ackst_q;
      end
      A_BAUD: rdata[RW-1:0] = rl_q;
      default: rdata[0] = flag_q;
    endcase
  end

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q); // R8
  AST_ACKST_ONLY_ON_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ackst_q != $past(ackst_q)) |-> $past(done && done_op == OP_TX)); // R5
  AST_LOCKED_BAUD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |=> $stable(rl_q)); // R9

endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2cm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RELOAD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              sda_i,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);

  logic                go, busy, done, ack_smp, nack, tick;
  op_t                 op, done_op;
  logic [DATA_W-1:0]   tx_byte, rx_byte;
  logic [RELOAD_W-1:0] reload;

  i2cm_hostregs #(.DW(DATA_W), .RW(RELOAD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .eng_busy (busy),
    .done     (done),
    .done_op  (done_op),
    .ack_smp  (ack_smp),
    .rx_byte  (rx_byte),
    .go       (go),
    .op       (op),
    .tx_byte  (tx_byte),
    .nack     (nack),
    .reload   (reload),
    .flag     (irq)
  );

  i2cm_baud #(.RW(RELOAD_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (busy),
    .reload (reload),
    .tick   (tick)
  );

  i2cm_engine #(.DW(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .op        (op),
    .tx_byte   (tx_byte),
    .nack_send (nack),
    .tick      (tick),
    .sda_i     (sda_i),
    .busy      (busy),
    .done      (done),
    .done_op   (done_op),
    .ack_smp   (ack_smp),
    .rx_byte   (rx_byte),
    .scl_low   (scl_drive_low),
    .sda_low   (sda_drive_low)
  );

endmodule

// File: tb/sim_i2c_step_master.sv
`timescale 1ns/1ps
module sim_i2c_step_master;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, scl_drive_low, sda_drive_low;
  logic       sda_i, scl_line, slave_low;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit ended  = 0;

  // bench slave model state
  int   sl_mode = 0;     // 0: acknowledges written bytes, 1: sends rbyte
  logic sl_nack = 1'b0;
  logic [7:0] rbyte = 8'h00;
  int   scnt = -1;
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  logic nack_seen = 1'b0;
  logic m_ack = 1'b0;
  logic [7:0] cap = 8'h00;
  int   n_rise = 0, n_start = 0, n_stop = 0;

  always #4 clk = ~clk;

  assign scl_line = !scl_drive_low;
  always_comb
    slave_low = (sl_mode == 0 && scnt == 8 && !sl_nack) ||
                (sl_mode == 1 && !nack_seen && scnt >= 0 && scnt < 8 && !rbyte[3'(7 - scnt)]);
  assign sda_i = !(sda_drive_low || slave_low);

  i2c_step_master u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sda_i(sda_i),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line && prev_scl && prev_sda && !sda_i) begin
        n_start++; scnt = -1; nack_seen = 1'b0;
      end
      if (scl_line && prev_scl && !prev_sda && sda_i) begin
        n_stop++; scnt = -1;
      end
      if (scl_line && !prev_scl) begin
        n_rise++;
        if (scnt >= 0 && scnt < 8) cap = {cap[6:0], sda_i};
        if (scnt == 8) begin
          m_ack = sda_i;
          if (sda_i) nack_seen = 1'b1;
        end
      end
      if (!scl_line && prev_scl) scnt = (scnt == 8) ? 0 : scnt + 1;
    end
    prev_scl = scl_line;
    prev_sda = sda_i;
  end

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
      summary();
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_irq(output int k);
    k = 1;
    while (!irq && k < 100000) begin
      @(negedge clk);
      k++;
    end
  endtask

  int k, h, r0, s0, p0;
  logic [7:0] v;
  logic [7:0] dat [6] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h80, 8'h01};
  int rls [4] = '{1, 2, 4, 0};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 scl released", scl_drive_low, 0);
    chk("R11 sda released", sda_drive_low, 0);
    chk("R11 irq", irq, 0);
    rd(2'd1, v); chk("R11 ctrl", v, 0);
    rd(2'd2, v); chk("R11 reload", v, 0);
    rd(2'd0, v); chk("R11 buffer", v, 0);

    foreach (rls[i]) begin
      h = ((rls[i] == 0) ? 1 : rls[i]) + 1;
      wr(2'd2, 8'(rls[i]));
      rd(2'd2, v); chk("R3 reload readback", v, rls[i]);

      // START
      wr(2'd3, 8'h00);
      s0 = n_start;
      sl_mode = 0;
      wr(2'd1, 8'h01);
      rd(2'd1, v); chk("R1 start bit pending", v[0], 1);
      wait_irq(k);
      chk("R3 start duration", k, 3 * h + 2);
      chk("R1 start seen", n_start, s0 + 1);
      rd(2'd1, v); chk("R1 start bit cleared", v[0], 0);
      chk("R1 scl low after start", scl_drive_low, 1);

      // address byte and data bytes, slave acknowledges or not
      for (int b = 0; b < 7; b++) begin
        logic [7:0] tb;
        tb = (b == 0) ? 8'hA4 : dat[b-1];
        sl_nack = (b % 3 == 2);
        wr(2'd3, 8'h00);
        r0 = n_rise;
        wr(2'd0, tb);
        if (b == 3 && i == 1) begin
          repeat (5) @(negedge clk);
          wr(2'd0, 8'h5A);
          wr(2'd2, 8'h33);
          wr(2'd1, 8'h04);
        end
        wait_irq(k);
        if (!(b == 3 && i == 1)) chk("R3 byte duration", k, 18 * h + 2);
        chk("R4 byte on bus", cap, tb);
        rd(2'd1, v); chk("R5 ack status", v[6], sl_nack);
        chk("R7 nine clocks", n_rise, r0 + 9);
        repeat (12) @(negedge clk);
        chk("R7 no clock while parked", n_rise, r0 + 9);
        chk("R7 scl parked low", scl_drive_low, 1);
        if (b == 3 && i == 1) begin
          rd(2'd2, v); chk("R9 reload kept", v, rls[i]);
          rd(2'd1, v); chk("R9 no stop queued", v[2], 0);
        end
      end

      // STOP written together with receive: only STOP kept
      sl_nack = 1'b0;
      wr(2'd3, 8'h00);
      p0 = n_stop; r0 = n_rise;
      wr(2'd1, 8'h0C);
      rd(2'd1, v); chk("R10 only stop kept", v[3:0], 4'b0100);
      wait_irq(k);
      chk("R3 stop duration", k, 3 * h + 2);
      chk("R2 stop seen", n_stop, p0 + 1);
      chk("R10 one clock rise", n_rise, r0 + 1);
      chk("R2 lines free", {scl_drive_low, sda_drive_low}, 0);
      rd(2'd1, v); chk("R2 stop bit cleared", v[2], 0);

      // read transfer
      wr(2'd3, 8'h00); wr(2'd1, 8'h01); wait_irq(k);
      wr(2'd3, 8'h00); wr(2'd0, 8'hA5); wait_irq(k);
      rd(2'd1, v); chk("R5 address acked", v[6], 0);
      sl_mode = 1; rbyte = 8'h96 ^ 8'(i * 37);
      wr(2'd3, 8'h00); wr(2'd1, 8'h08); wait_irq(k);
      chk("R3 receive duration", k, 18 * h + 2);
      rd(2'd0, v); chk("R6 received byte", v, 8'h96 ^ 8'(i * 37));
      chk("R6 master ack", m_ack, 0);
      rbyte = 8'h4B + 8'(i);
      wr(2'd3, 8'h00); wr(2'd1, 8'h28); wait_irq(k);
      rd(2'd0, v); chk("R6 second byte", v, 8'h4B + 8'(i));
      chk("R6 master nack", m_ack, 1);
      sl_mode = 0;
      s0 = n_start;
      wr(2'd3, 8'h00); wr(2'd1, 8'h02); wait_irq(k);
      chk("R1 repeated start seen", n_start, s0 + 1);
      rd(2'd1, v); chk("R1 rstart bit cleared", v[1], 0);
      wr(2'd3, 8'h00); wr(2'd1, 8'h04); wait_irq(k);
    end

    // completion and clear on the same edge (reload 0, h = 2)
    h = 2;
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h01);
    repeat (3 * h - 1) @(negedge clk);
    wr(2'd3, 8'h00);
    chk("R8 set wins over clear", irq, 1);
    wr(2'd3, 8'h01);
    chk("R8 writing one keeps flag", irq, 1);
    wr(2'd3, 8'h00);
    chk("R8 clear works", irq, 0);
    rd(2'd3, v); chk("R8 flag readback", v, 0);
    wr(2'd1, 8'h04); wait_irq(k);
    chk("R2 final stop", {scl_drive_low, sda_drive_low}, 0);

    summary();
  end

endmodule